// File: doc/BRIEF.md
# Persistent DC Offset Window Monitor

This block decides, for each of several amplifier output channels, whether a DC offset stayed excessive for the whole of a test window whose length the host sets. An analog comparator per channel raises a level when the output carries more than about two volts of DC. That level reaches this block asynchronously and is resynchronised here. A measurement window opens when the host sets its offset-enable control. The window closes on each status read. The read returns one flag per channel, and that flag is set only if the comparator was seen high on every sample of the window that just ended. The same read opens a fresh window, so a host that enables the test, waits some tens of milliseconds and then reads repeatedly sees each flag clear once the offset has gone.

If any channel's short-circuit protection fires inside a window, the whole window is void and every flag of that read returns clear. A window too short to hold a full synchroniser delay of samples also returns clear. The "active" output follows the enable control one cycle late and is meant to be reported next to the flags.

Top module: `dc_offset_window_mon`

## Requirements
- R1: After reset, `ofs_flag` is all zeros and `ofs_active` is 0.
- R2: `ofs_active` equals the value of `ofs_en` sampled at the previous rising clock edge.
- R3: A window starts at an edge where `ofs_en` is 1 and either `ofs_active` is 0 or `status_rd` is 1. At the edge where `status_rd` is 1, bit i of `ofs_flag` becomes 1 when three things hold: every comparator sample of channel i taken at the edges strictly between the start edge and that read edge was 1, where each sample is `ofs_cmp[i]` delayed by SYNC_STAGES flops (default 2); no window was void; and the window was long enough.
- R4: A single 0 sample of `ofs_cmp[i]` inside the window makes bit i of the next read result 0.
- R5: A 1 sample on any bit of `scp_act` (delayed by SYNC_STAGES flops) inside the window makes every bit of the next read result 0.
- R6: `ofs_flag` changes only at edges where `status_rd` is 1, and holds its value until the next read. A read while enabled restarts the window.
- R7: If fewer than SYNC_STAGES edges lie strictly between the start edge and the read edge, the read result is all zeros.
- R8: A read while `ofs_active` is 0 returns all zeros.
- R9: Channels are evaluated independently: bit i of `ofs_flag` depends only on bit i of `ofs_cmp`, apart from the global void of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofs_en | input | 1 | Offset test enable level from the control register |
| status_rd | input | 1 | One-cycle pulse per host status read |
| ofs_cmp | input | NUM_CH | Asynchronous per-channel offset-exceeded comparator levels |
| scp_act | input | NUM_CH | Asynchronous per-channel short-circuit protection active levels |
| ofs_flag | output | NUM_CH | Per-channel persistent-offset result of the last closed window |
| ofs_active | output | 1 | Offset test enabled (window tracking running) |

## Verification
The assertions assume that `status_rd` is a pulse synchronous to `clk` and that `ofs_en` changes only between edges. No assumption is made about the comparator or protection inputs, which may toggle on any cycle. The random stimulus drives every input at the falling edge. It holds read pulses to a single cycle and lets the comparator and protection levels change freely, with a bias toward long runs of high comparator levels, so that both set and cleared results occur often.

// File: rtl/dcow_pkg.sv
package dcow_pkg;

   // Window control bundle shared between the window controller and
   // the per-channel trackers.
   typedef struct packed {
      logic open;    // a window is being accumulated
      logic start;   // window (re)starts at this edge
      logic close;   // window closes at this edge (status read)
      logic voided;  // protection event seen inside the current window
      logic aged;    // window holds at least SYNC_STAGES samples
   } win_ctl_t;

   function automatic int unsigned cnt_width(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/dcow_sync_bank.sv
module dcow_sync_bank #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dcow_sync_bank: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dcow_sync_bank: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/dcow_window_ctrl.sv
module dcow_window_ctrl
   import dcow_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ofs_en,
   input  logic              status_rd,
   input  logic [NUM_CH-1:0] scp_sync,
   output win_ctl_t          ctl
);

   localparam int unsigned AGE_W = cnt_width(SYNC_STAGES);
   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SYNC_STAGES);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("dcow_window_ctrl: NUM_CH must be at least 1");
   end

   logic             en_q;
   logic [AGE_W-1:0] age_q;
   logic             void_q;
   logic             start;
   logic             any_scp;

   assign any_scp = |scp_sync;
   assign start   = ofs_en & (~en_q | status_rd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         age_q  <= '0;
         void_q <= 1'b0;
      end else begin
         en_q <= ofs_en;
         if (start) begin
            age_q  <= '0;
            void_q <= 1'b0;
         end else if (en_q) begin
            if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
            if (any_scp)          void_q <= 1'b1;
         end
      end
   end

   assign ctl.open   = en_q;
   assign ctl.start  = start;
   assign ctl.close  = status_rd;
   assign ctl.voided = void_q;
   assign ctl.aged   = (age_q == AGE_MAX);

   // R6: a restart clears the age and the void mark
   p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (age_q == '0) && !void_q);

   // R5: a protection sample inside an open window marks it void
   p_scp_voids_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !start && any_scp) |=> void_q);

   // R7: age never exceeds its saturation value
   p_age_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= AGE_MAX);

endmodule

// File: rtl/dcow_chan_track.sv
module dcow_chan_track
   import dcow_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  win_ctl_t ctl,
   input  logic     cmp_sync,
   output logic     flag
);

   logic ever_low_q;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ever_low_q <= 1'b0;
      end else if (ctl.start) begin
         ever_low_q <= 1'b0;
      end else if (ctl.open && !cmp_sync) begin
         ever_low_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (ctl.close) begin
         flag_q <= ctl.open & ctl.aged & ~ctl.voided & ~ever_low_q;
      end
   end

   assign flag = flag_q;

   // R4: a low sample seen in the window forbids the flag at the read
   p_low_blocks_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.close && ever_low_q) |=> !flag_q);

   // R6: result only moves at a read
   p_hold_between_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.close |=> $stable(flag_q));

endmodule

// File: rtl/dc_offset_window_mon.sv
module dc_offset_window_mon
   import dcow_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ofs_en,
   input  logic              status_rd,
   input  logic [NUM_CH-1:0] ofs_cmp,
   input  logic [NUM_CH-1:0] scp_act,
   output logic [NUM_CH-1:0] ofs_flag,
   output logic              ofs_active
);

   win_ctl_t          ctl;
   logic [NUM_CH-1:0] cmp_sync;
   logic [NUM_CH-1:0] scp_sync;

   dcow_sync_bank #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_cmp_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ofs_cmp),
      .q_sync  (cmp_sync)
   );

   dcow_sync_bank #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_scp_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (scp_act),
      .q_sync  (scp_sync)
   );

   dcow_window_ctrl #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ofs_en    (ofs_en),
      .status_rd (status_rd),
      .scp_sync  (scp_sync),
      .ctl       (ctl)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      dcow_chan_track u_track (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctl      (ctl),
         .cmp_sync (cmp_sync[c]),
         .flag     (ofs_flag[c])
      );
   end

   assign ofs_active = ctl.open;

   // R8: a read with the test disabled returns nothing
   p_idle_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !ofs_active) |=> (ofs_flag == '0));

   // R5: a voided window returns nothing
   p_void_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && ctl.voided) |=> (ofs_flag == '0));

   // R7: a too-short window returns nothing
   p_short_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !ctl.aged) |=> (ofs_flag == '0));

   // R2: active follows the enable by one edge
   p_active_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ofs_en) |=> ofs_active);

endmodule

// File: tb/dc_offset_window_mon_tb.sv
module dc_offset_window_mon_tb;

   localparam int NCH  = 4;
   localparam int SYNC = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ofs_en = 1'b0;
   logic           status_rd = 1'b0;
   logic [NCH-1:0] ofs_cmp = '0;
   logic [NCH-1:0] scp_act = '0;
   logic [NCH-1:0] ofs_flag;
   logic           ofs_active;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;   // 125 MHz

   dc_offset_window_mon #(.NUM_CH(NCH), .SYNC_STAGES(SYNC)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ofs_en     (ofs_en),
      .status_rd  (status_rd),
      .ofs_cmp    (ofs_cmp),
      .scp_act    (scp_act),
      .ofs_flag   (ofs_flag),
      .ofs_active (ofs_active)
   );

   // Reference model built from the requirements
   logic [NCH-1:0] m_ch [SYNC];
   logic [NCH-1:0] m_sh [SYNC];
   logic           m_enq;
   logic [NCH-1:0] m_low;
   logic           m_void;
   int             m_age;
   logic [NCH-1:0] m_flag;

   function automatic logic [NCH-1:0] read_result(input logic enq,
      input logic [NCH-1:0] low, input logic vd, input int age);
      if (!enq || vd || age < SYNC) return '0;
      return ~low;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SYNC; k++) begin
            m_ch[k] <= '0;
            m_sh[k] <= '0;
         end
         m_enq <= 1'b0; m_low <= '0; m_void <= 1'b0; m_age <= 0; m_flag <= '0;
      end else begin
         m_ch[0] <= ofs_cmp;
         m_sh[0] <= scp_act;
         for (int k = 1; k < SYNC; k++) begin
            m_ch[k] <= m_ch[k-1];
            m_sh[k] <= m_sh[k-1];
         end
         if (status_rd) m_flag <= read_result(m_enq, m_low, m_void, m_age);
         if (ofs_en && (!m_enq || status_rd)) begin
            m_low <= '0; m_void <= 1'b0; m_age <= 0;
         end else if (m_enq) begin
            m_low <= m_low | ~m_ch[SYNC-1];
            if (|m_sh[SYNC-1]) m_void <= 1'b1;
            if (m_age < SYNC) m_age <= m_age + 1;
         end
         m_enq <= ofs_en;
      end
   end

   task automatic chk(input string tag, input logic [NCH-1:0] act,
                      input logic [NCH-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // pulse a read, then sample after the edge that latched it
   task automatic do_read(input string tag);
      @(negedge clk);
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      chk(tag, ofs_flag, m_flag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : stim
      logic [NCH-1:0] held;
      logic [NCH-1:0] stuck;
      void'($urandom(32'h5eed_0ff5));
      idle(3);
      // R1: reset state
      chk("R1 flags", ofs_flag, '0);
      chk("R1 active", {3'b0, ofs_active}, '0);
      rst_n = 1'b1;
      idle(2);

      // R8: read while disabled
      ofs_cmp = '1;
      idle(4);
      do_read("R8 disabled read");
      chk("R8 zero", ofs_flag, '0);

      // R2: active one edge after enable
      @(negedge clk);
      ofs_en = 1'b1;
      @(negedge clk);
      chk("R2 active", {3'b0, ofs_active}, 4'b0001);

      // R7: read right after start (no full sync delay)
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      chk("R7 short window", ofs_flag, '0);

      // R3: long window, all high
      idle(20);
      do_read("R3 model");
      chk("R3 all set", ofs_flag, 4'hF);

      // R4 / R9: single low glitch on channel 2 only
      idle(5);
      ofs_cmp[2] = 1'b0;
      @(negedge clk);
      ofs_cmp[2] = 1'b1;
      idle(10);
      do_read("R4 model");
      chk("R4 R9 glitch ch2", ofs_flag, 4'b1011);

      // R6: flags hold between reads while inputs change
      held = ofs_flag;
      ofs_cmp = 4'b0000;
      idle(12);
      chk("R6 hold", ofs_flag, held);
      ofs_cmp = '1;
      idle(10);
      do_read("R6 restart");
      chk("R6 restarted low", ofs_flag, 4'b0000);
      idle(10);
      do_read("R6 next window");
      chk("R6 next set", ofs_flag, 4'hF);

      // R5: protection pulse on one channel voids all
      idle(4);
      scp_act[1] = 1'b1;
      @(negedge clk);
      scp_act[1] = 1'b0;
      idle(8);
      do_read("R5 model");
      chk("R5 void", ofs_flag, '0);

      // R2: disable drops active
      ofs_en = 1'b0;
      @(negedge clk);
      chk("R2 inactive", {3'b0, ofs_active}, 4'b0000);
      do_read("R8 after disable");

      // Random phase, R3 R4 R5 R6 R7 R9 against the model
      for (int it = 0; it < 500; it++) begin
         int len;
         if ($urandom_range(7) == 0) ofs_en = ~ofs_en;
         else if (!ofs_en && $urandom_range(1)) ofs_en = 1'b1;
         stuck = NCH'($urandom);
         len = $urandom_range(30);
         for (int c = 0; c < len; c++) begin
            @(negedge clk);
            for (int ch = 0; ch < NCH; ch++)
               ofs_cmp[ch] = stuck[ch] ? 1'b1 : ($urandom_range(7) != 0);
            scp_act = ($urandom_range(63) == 0) ? NCH'($urandom) : '0;
         end
         do_read("R3 R4 R5 R7 R9 random");
         chk("R2 random active", {3'b0, ofs_active}, {3'b0, m_enq});
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule